// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands in pure combinational logic. A grid of AND gates forms every partial-product bit from one multiplicand bit and one multiplier bit. Those bits are then summed by rows of half-adder and full-adder cells. Each row keeps its carries in a separate vector. It passes that vector down to the next row, one column toward the more significant end, so no carry ripples sideways inside a row. The lowest bit of each row's sum vector is final and leaves the array as one of the low product bits. After the last row, a single ripple-carry adder merges the remaining sum and carry vectors into the upper product bits.

The multiplicand width and the multiplier width are separate parameters, each at least 2. The default is 4 by 4, which gives an 8-bit product. Other shapes are generated from the same description, for example 6 by 4 or 8 by 8. The block holds no state, and the product settles a fixed logic delay after the operands change. This block has no handshake: it is plain combinational arithmetic. Any valid/ready framing belongs to the register stage that surrounds it.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of 4-bit unsigned operands, the 8-bit product output equals the arithmetic product of multiplicand and multiplier.
- R2: When either operand is zero, every product bit is zero.
- R3: Product bit 0 equals the AND of bit 0 of the multiplicand and bit 0 of the multiplier.
- R4: When one operand equals one, the product equals the other operand, zero-extended to the product width.
- R5: In the 6-by-4 shape, the multiplicand 101010 (binary) times the multiplier 1011 (binary) yields the product 111001110 (binary).
- R6: When both operands are all ones, the product is (2^MC_W - 1)(2^MP_W - 1), with no wrap-around in the top bits. For 4 by 4 this is 225.
- R7: Wider shapes (6 by 4 and 8 by 8) produce the exact arithmetic product for arbitrary operand values.
- R8: The product never exceeds (2^MC_W - 1)(2^MP_W - 1).
- R9: When the multiplier is a power of two, 2^k, the product equals the multiplicand shifted left by k places.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | MC_W | Unsigned multiplicand (default 4 bits) |
| mplier_i | input | MP_W | Unsigned multiplier (default 4 bits) |
| product_o | output | MC_W+MP_W | Unsigned product (default 8 bits) |

## Verification
The assertions are immediate checks on the settled combinational result. They assume the operands are fully driven two-state values that hold still long enough for the array to settle. They also assume both widths are at least 2, because a one-bit operand leaves no reduction row to build. The bench holds every operand pair constant across a whole clock period, and it reads the product only half a period after driving it. It also instantiates only shapes with both widths of 2 or more, so every check sees a settled value.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;

  // Role of one cell in the reduction array.
  typedef enum logic [1:0] {
    CELL_PASS,      // lone partial product, nothing to add
    CELL_HALF_SUM,  // first row: partial product + sum from above
    CELL_HALF_CARRY,// top column of later rows: partial product + carry
    CELL_FULL       // partial product + sum + carry
  } cell_kind_e;

  function automatic cell_kind_e cell_kind(input int row, input int col, input int width);
    if (row == 1 && col == width - 1) return CELL_PASS;
    if (row == 1)                     return CELL_HALF_SUM;
    if (col == width - 1)             return CELL_HALF_CARRY;
    return CELL_FULL;
  endfunction

endpackage

// File: rtl/csa_half_cell.sv
module csa_half_cell (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = a_i ^ b_i;
  assign cry_o = a_i & b_i;
endmodule

// File: rtl/csa_full_cell.sv
module csa_full_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic cry_o
);
  logic prop;
  assign prop  = a_i ^ b_i;
  assign sum_o = prop ^ c_i;
  assign cry_o = (a_i & b_i) | (prop & c_i);
endmodule

// File: rtl/csa_pp_grid.sv
module csa_pp_grid #(
  parameter int MC_W = 4,
  parameter int MP_W = 4
) (
  input  logic [MC_W-1:0]            mc_i,
  input  logic [MP_W-1:0]            mp_i,
  output logic [MP_W-1:0][MC_W-1:0]  pp_o
);
  // Row j holds multiplicand bits gated by multiplier bit j.
  for (genvar j = 0; j < MP_W; j++) begin : g_row
    for (genvar i = 0; i < MC_W; i++) begin : g_col
      assign pp_o[j][i] = mc_i[i] & mp_i[j];
    end
  end
endmodule

// File: rtl/csa_merge_adder.sv
module csa_merge_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int CW = W - 1;
  logic [CW-1:0] cry;

  csa_half_cell u_lsb (
    .a_i(a_i[0]), .b_i(b_i[0]), .sum_o(sum_o[0]), .cry_o(cry[0])
  );

  for (genvar k = 1; k < W - 1; k++) begin : g_mid
    csa_full_cell u_fa (
      .a_i(a_i[k]), .b_i(b_i[k]), .c_i(cry[k-1]),
      .sum_o(sum_o[k]), .cry_o(cry[k])
    );
  end

  // The top position cannot overflow: the product fits the output width.
  assign sum_o[W-1] = a_i[W-1] ^ b_i[W-1] ^ cry[CW-1];
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult
  import csa_mul_pkg::*;
#(
  parameter int MC_W = 4,
  parameter int MP_W = 4
) (
  input  logic [MC_W-1:0]      mcand_i,
  input  logic [MP_W-1:0]      mplier_i,
  output logic [MC_W+MP_W-1:0] product_o
);
  localparam int PW = MC_W + MP_W;

  logic [MP_W-1:0][MC_W-1:0] pp;
  logic [MP_W-1:0][MC_W-1:0] srow;   // sum vector leaving each row
  logic [MP_W-1:1][MC_W-1:0] crow;   // carry vector leaving each row

  csa_pp_grid #(.MC_W(MC_W), .MP_W(MP_W)) u_pp (
    .mc_i(mcand_i), .mp_i(mplier_i), .pp_o(pp)
  );

  assign srow[0] = pp[0];

  for (genvar j = 1; j < MP_W; j++) begin : g_row
    for (genvar i = 0; i < MC_W; i++) begin : g_cell
      localparam cell_kind_e KIND = cell_kind(j, i, MC_W);
      if (KIND == CELL_PASS) begin : g_pass
        assign srow[j][i] = pp[j][i];
        assign crow[j][i] = 1'b0;
      end else if (KIND == CELL_HALF_SUM) begin : g_hs
        csa_half_cell u_ha (
          .a_i(pp[j][i]), .b_i(srow[j-1][i+1]),
          .sum_o(srow[j][i]), .cry_o(crow[j][i])
        );
      end else if (KIND == CELL_HALF_CARRY) begin : g_hc
        csa_half_cell u_ha (
          .a_i(pp[j][i]), .b_i(crow[j-1][i]),
          .sum_o(srow[j][i]), .cry_o(crow[j][i])
        );
      end else begin : g_full
        csa_full_cell u_fa (
          .a_i(pp[j][i]), .b_i(srow[j-1][i+1]), .c_i(crow[j-1][i]),
          .sum_o(srow[j][i]), .cry_o(crow[j][i])
        );
      end
    end
  end

  // Low product bits: lowest sum bit of each row is final.
  for (genvar j = 0; j < MP_W; j++) begin : g_low
    assign product_o[j] = srow[j][0];
  end

  // Vector merge of the last row's remaining sums and carries.
  csa_merge_adder #(.W(MC_W)) u_merge (
    .a_i  ({1'b0, srow[MP_W-1][MC_W-1:1]}),
    .b_i  (crow[MP_W-1]),
    .sum_o(product_o[PW-1:MP_W])
  );
endmodule

// File: rtl/csa_array_mult_chk.sv
module csa_array_mult_chk #(
  parameter int MC_W = 4,
  parameter int MP_W = 4
) (
  input logic [MC_W-1:0]      mc,
  input logic [MP_W-1:0]      mp,
  input logic [MC_W+MP_W-1:0] prod
);
  localparam int PW = MC_W + MP_W;
  localparam logic [PW-1:0] MC_MAX = {{MP_W{1'b0}}, {MC_W{1'b1}}};
  localparam logic [PW-1:0] MP_MAX = {{MC_W{1'b0}}, {MP_W{1'b1}}};
  localparam logic [PW-1:0] BOUND  = MC_MAX * MP_MAX;

  logic [PW-1:0] mc_x, mp_x, arith;
  always_comb begin
    mc_x  = {{MP_W{1'b0}}, mc};
    mp_x  = {{MC_W{1'b0}}, mp};
    arith = mc_x * mp_x;
  end

  always_comb begin
    // R1 / R7
    a_r1_exact_product: assert (prod == arith)
      else $error("product %0h differs from %0h", prod, arith);
    // R2
    a_r2_zero_operand: assert (!(mc == '0 || mp == '0) || prod == '0)
      else $error("zero operand gave %0h", prod);
    // R3
    a_r3_lsb_and: assert (prod[0] == (mc[0] & mp[0]))
      else $error("bit 0 mismatch");
    // R4
    a_r4_unit_mult: assert (mp != 1 || prod == mc_x)
      else $error("times one gave %0h", prod);
    // R8
    a_r8_bounded: assert (prod <= BOUND)
      else $error("product %0h above bound", prod);
  end
endmodule

bind csa_array_mult csa_array_mult_chk #(.MC_W(MC_W), .MP_W(MP_W)) u_chk (
  .mc(mcand_i), .mp(mplier_i), .prod(product_o)
);

// File: tb/csa_array_mult_test.sv
module csa_array_mult_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0] a4, b4;
  logic [7:0] p4;
  logic [5:0] a6;
  logic [3:0] b6;
  logic [9:0] p6;
  logic [7:0] a8, b8;
  logic [15:0] p8;

  csa_array_mult #(.MC_W(4), .MP_W(4)) uut (.mcand_i(a4), .mplier_i(b4), .product_o(p4));
  csa_array_mult #(.MC_W(6), .MP_W(4)) uut_w (.mcand_i(a6), .mplier_i(b6), .product_o(p6));
  csa_array_mult #(.MC_W(8), .MP_W(8)) uut_b (.mcand_i(a8), .mplier_i(b8), .product_o(p8));

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_all(input int x4, input int y4, input int x6, input int y6,
                           input int x8, input int y8);
    @(negedge clk);
    a4 = 4'(x4); b4 = 4'(y4);
    a6 = 6'(x6); b6 = 4'(y6);
    a8 = 8'(x8); b8 = 8'(y8);
    @(posedge clk);
    #1;
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    if (rst_n) wd <= wd + 1;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected below %0d", wd, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    a4 = '0; b4 = '0; a6 = '0; b6 = '0; a8 = '0; b8 = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Idle state: zero operands give zero (R2)
    check("R2 idle", p4, 0);
    check("R2 idle wide", p6, 0);

    // R1 exhaustive 4x4, with R2, R3, R4, R9 checked along the way
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        drive_all(x, y, 0, 0, 0, 0);
        check("R1", p4, x * y);
        check("R3", p4[0], (x & y) & 1);
        if (x == 0 || y == 0) check("R2", p4, 0);
        if (y == 1) check("R4", p4, x);
        if (x == 1) check("R4", p4, y);
        if (y == 1 || y == 2 || y == 4 || y == 8)
          check("R9", p4, (x * y) & 8'hFF);
      end
    end

    // R5 fixed vector for 6x4: 101010 * 1011 = 111001110
    drive_all(0, 0, 6'b101010, 4'b1011, 0, 0);
    check("R5", p6, 10'b0111001110);

    // R6 all ones
    drive_all(15, 15, 63, 15, 255, 255);
    check("R6 4x4", p4, 225);
    check("R6 6x4", p6, 63 * 15);
    check("R6 8x8", p8, 255 * 255);

    // R9 powers of two in wide shapes
    for (int k = 0; k < 4; k++) begin
      drive_all(0, 0, 45, 1 << k, 201, 1 << (2 * k + 1));
      check("R9 6x4", p6, 45 << k);
      check("R9 8x8", p8, 201 << (2 * k + 1));
    end

    // R7 random wide operands
    for (int r = 0; r < 300; r++) begin
      int x6v, y6v, x8v, y8v;
      x6v = int'($urandom_range(63));
      y6v = int'($urandom_range(15));
      x8v = int'($urandom_range(255));
      y8v = int'($urandom_range(255));
      drive_all(0, 0, x6v, y6v, x8v, y8v);
      check("R7 6x4", p6, x6v * y6v);
      check("R7 8x8", p8, x8v * y8v);
      check("R3 8x8", p8[0], (x8v & y8v) & 1);
    end

    // R8 bound after sweep of the 6x4 shape against max
    drive_all(0, 0, 63, 15, 0, 0);
    check("R8", (p6 <= 10'(63 * 15)) ? 1 : 0, 1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule